// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block brings a DDR memory from power-on to a ready state. It drives the clock-enable, command and address pins of the memory. No other master may use those pins until the block reports that it has finished. After reset it keeps clock enable low and sends no-operation commands for a programmable number of cycles. It then raises clock enable and waits a short lead time.

After that wait it issues a fixed command script. First comes an extended mode write that turns the DLL on. Next is a mode write that resets the DLL, followed by a wait for the DLL to lock. It then issues a precharge of every bank and a programmable number of auto refreshes. The last command is a mode write that sets normal operation.

The burst length, addressing order and CAS latency of the operating mode come from configuration inputs. All waits are parameters counted in clock cycles. Once the final mode write has had its register cycle time, a done flag rises and stays high. From then on the block only sends no-operation commands with clock enable high.

Top module: `pwrup_seq`

## Requirements
- R1: `rst_n` low clears the block at once, asynchronously. In that state `ddr_cke`=0, the command pins {cs_n,ras_n,cas_n,we_n}=0111 (NOP), `ddr_ba`=0, `ddr_addr`=0 and `init_done`=0. Release passes through a two-stage synchronizer. `ddr_cke` stays low with NOP until it rises with clock edge POWER_WAIT+2 after `rst_n` rises.
- R2: CKE_LEAD cycles after `ddr_cke` rises, an extended mode write is issued. Its command pins are 0000, `ddr_ba`=01 and `ddr_addr`=0, so A0=0 enables the DLL.
- R3: MODE_GAP cycles after the extended mode write, a mode write is issued. Its pins are 0000, `ddr_ba`=00, A8=1 (DLL reset), and the operating fields of R7 are set.
- R4: DLL_LOCK cycles after the DLL-reset write, a precharge-all is issued with pins 0010 and A10=1. All other address bits and `ddr_ba` are 0.
- R5: PRE_GAP cycles after the precharge, the first auto refresh (pins 0001) is issued. REF_COUNT refreshes are issued in all, each REF_GAP cycles after the one before.
- R6: REF_GAP cycles after the last refresh, the final mode write is issued with pins 0000, `ddr_ba`=00 and A8=0.
- R7: Every mode write carries A2..A0 = 001, 010 or 011 for `cfg_burst` = 0, 1 or 2/3. It carries A3=`cfg_interleave`, and A6..A4 = 100 when `cfg_cl4`=1, else 011. All other address bits are 0. The configuration is taken at the clock edge that launches each mode write.
- R8: Every cycle that carries none of the commands above is NOP with `ddr_ba`=0 and `ddr_addr`=0. Two mode-register writes are never less than MODE_GAP cycles apart.
- R9: `init_done` rises MODE_GAP cycles after the final mode write. It then stays high while `ddr_cke` stays high and the pins stay NOP. Configuration changes after that have no effect on any output.
- R10: Asserting `rst_n` in the middle of the script returns all outputs to the R1 state immediately. The next release restarts the whole script from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst | input | 2 | Burst length select: 0 gives 2, 1 gives 4, 2/3 give 8 |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_cl4 | input | 1 | 1 selects CAS latency 4, 0 selects 3 |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BANK_W | Bank select; bit 0 picks the extended mode register |
| ddr_addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
A configuration change can coincide with the launch of a mode write, because the mode word is taken from the live inputs at the launching edge. The bench starts a run with one configuration and switches to another at the falling edge just before the edge that launches the final mode write. It expects the DLL-reset write to carry the first word and the final write to carry the second. A third change, made after `init_done` has risen, must leave every output unchanged.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_MODE,
    CMD_PREALL,
    CMD_REFRESH
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_CKE,
    ST_EMODE,
    ST_EMODE_GAP,
    ST_DLLRST,
    ST_DLL_WAIT,
    ST_PREALL,
    ST_PRE_WAIT,
    ST_REFRESH,
    ST_REF_WAIT,
    ST_MODE_FIN,
    ST_FIN_WAIT,
    ST_READY
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[N-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[N-1];
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int          W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R8
  timer_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q != '1));
endmodule

// File: rtl/pwrup_cmd_enc.sv
module pwrup_cmd_enc
  import pwrup_pkg::*;
(
  input  ddr_cmd_e  cmd,
  output cmd_pins_t pins
);
  always_comb begin
    unique case (cmd)
      CMD_MODE:    pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_PREALL:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REFRESH: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default:     pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  end
endmodule

// File: rtl/pwrup_mode_word.sv
module pwrup_mode_word #(
  parameter int AW = 12
) (
  input  logic [1:0]    burst_sel,
  input  logic          interleave,
  input  logic          cl4,
  input  logic          dll_reset,
  output logic [AW-1:0] word
);
  logic [2:0] bl_code;

  always_comb begin
    unique case (burst_sel)
      2'd0:    bl_code = 3'b001;
      2'd1:    bl_code = 3'b010;
      default: bl_code = 3'b011;
    endcase
  end

  always_comb begin
    word      = '0;
    word[2:0] = bl_code;
    word[3]   = interleave;
    word[6:4] = cl4 ? 3'b100 : 3'b011;
    word[8]   = dll_reset;
  end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BANK_W     = 2,
  parameter int POWER_WAIT = 20000,
  parameter int CKE_LEAD   = 4,
  parameter int MODE_GAP   = 2,
  parameter int DLL_LOCK   = 200,
  parameter int PRE_GAP    = 4,
  parameter int REF_GAP    = 14,
  parameter int REF_COUNT  = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_burst,
  input  logic              cfg_interleave,
  input  logic              cfg_cl4,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BANK_W-1:0] ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);
  // waits clamped to the minimum the counter scheme supports
  localparam int P_HOLD = (POWER_WAIT < 2) ? 2 : POWER_WAIT;
  localparam int P_LEAD = (CKE_LEAD   < 1) ? 1 : CKE_LEAD;
  localparam int G_MODE = (MODE_GAP   < 2) ? 2 : MODE_GAP;
  localparam int G_DLL  = (DLL_LOCK   < 2) ? 2 : DLL_LOCK;
  localparam int G_PRE  = (PRE_GAP    < 2) ? 2 : PRE_GAP;
  localparam int G_REF  = (REF_GAP    < 2) ? 2 : REF_GAP;
  localparam int N_REF  = (REF_COUNT  < 1) ? 1 : REF_COUNT;

  localparam int MAX_A  = (P_HOLD > G_DLL) ? P_HOLD : G_DLL;
  localparam int MAX_B  = (G_REF > P_LEAD) ? G_REF : P_LEAD;
  localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam int REF_W  = $clog2(N_REF + 1);
  localparam int GAP_W  = $clog2(G_MODE + 1) + 1;

  logic rst_int_n;

  pwrup_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  seq_state_e        state_q, state_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic [REF_W-1:0]  ref_left_q, ref_left_d;
  logic              ref_load, ref_dec;

  pwrup_timer #(.W(CNT_W), .RST_VAL(P_HOLD - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_load = 1'b0;
    ref_dec  = 1'b0;
    unique case (state_q)
      ST_HOLD: if (tmr_zero) begin
        state_d = ST_CKE; tmr_load = 1'b1; tmr_val = CNT_W'(P_LEAD - 1);
      end
      ST_CKE: if (tmr_zero) state_d = ST_EMODE;
      ST_EMODE: begin
        state_d = ST_EMODE_GAP; tmr_load = 1'b1; tmr_val = CNT_W'(G_MODE - 2);
      end
      ST_EMODE_GAP: if (tmr_zero) state_d = ST_DLLRST;
      ST_DLLRST: begin
        state_d = ST_DLL_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(G_DLL - 2);
      end
      ST_DLL_WAIT: if (tmr_zero) state_d = ST_PREALL;
      ST_PREALL: begin
        state_d = ST_PRE_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(G_PRE - 2);
        ref_load = 1'b1;
      end
      ST_PRE_WAIT: if (tmr_zero) state_d = ST_REFRESH;
      ST_REFRESH: begin
        state_d = ST_REF_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(G_REF - 2);
        ref_dec = 1'b1;
      end
      ST_REF_WAIT: if (tmr_zero) state_d = (ref_left_q == '0) ? ST_MODE_FIN : ST_REFRESH;
      ST_MODE_FIN: begin
        state_d = ST_FIN_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(G_MODE - 2);
      end
      ST_FIN_WAIT: if (tmr_zero) state_d = ST_READY;
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_HOLD;
    endcase
  end

  always_comb begin
    ref_left_d = ref_left_q;
    if (ref_load)     ref_left_d = REF_W'(N_REF);
    else if (ref_dec) ref_left_d = ref_left_q - 1'b1;
  end

  // output values for the state being entered
  ddr_cmd_e          cmd_d;
  cmd_pins_t         pins_d, pins_q;
  logic [BANK_W-1:0] ba_d;
  logic [ADDR_W-1:0] addr_d, mode_word;
  logic              cke_d, done_d;

  pwrup_mode_word #(.AW(ADDR_W)) u_mode_word (
    .burst_sel  (cfg_burst),
    .interleave (cfg_interleave),
    .cl4        (cfg_cl4),
    .dll_reset  (state_d == ST_DLLRST),
    .word       (mode_word)
  );

  pwrup_cmd_enc u_cmd_enc (
    .cmd  (cmd_d),
    .pins (pins_d)
  );

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    cke_d  = (state_d != ST_HOLD);
    done_d = (state_d == ST_READY);
    unique case (state_d)
      ST_EMODE: begin
        cmd_d = CMD_MODE; ba_d = BANK_W'(1);
      end
      ST_DLLRST, ST_MODE_FIN: begin
        cmd_d = CMD_MODE; addr_d = mode_word;
      end
      ST_PREALL: begin
        cmd_d = CMD_PREALL; addr_d[10] = 1'b1;
      end
      ST_REFRESH: cmd_d = CMD_REFRESH;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_HOLD;
      ref_left_q <= '0;
      pins_q     <= '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      ddr_ba     <= '0;
      ddr_addr   <= '0;
      ddr_cke    <= 1'b0;
      init_done  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_left_q <= ref_left_d;
      pins_q     <= pins_d;
      ddr_ba     <= ba_d;
      ddr_addr   <= addr_d;
      ddr_cke    <= cke_d;
      init_done  <= done_d;
    end
  end

  assign ddr_cs_n  = pins_q.cs_n;
  assign ddr_ras_n = pins_q.ras_n;
  assign ddr_cas_n = pins_q.cas_n;
  assign ddr_we_n  = pins_q.we_n;

  // checking logic: cycles since the last mode-register write
  logic             pin_nop, pin_mode, pin_pre;
  logic [GAP_W-1:0] since_mode_q;

  assign pin_nop  = !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n;
  assign pin_mode = !ddr_cs_n && !ddr_ras_n && !ddr_cas_n && !ddr_we_n;
  assign pin_pre  = !ddr_cs_n && !ddr_ras_n && ddr_cas_n && !ddr_we_n;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)              since_mode_q <= '1;
    else if (pin_mode)           since_mode_q <= GAP_W'(1);
    else if (since_mode_q != '1) since_mode_q <= since_mode_q + 1'b1;
  end

  // R1
  cke_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ddr_cke |=> ddr_cke);

  // R1
  nop_while_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ddr_cke |-> pin_nop);

  // R4
  preall_a10_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_pre |-> ddr_addr[10]);

  // R7
  mode_cl_legal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin_mode && ddr_ba == '0) |-> (ddr_addr[6:4] == 3'b011 || ddr_addr[6:4] == 3'b100));

  // R8
  mode_spacing_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_mode |-> (since_mode_q >= GAP_W'(G_MODE)));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    init_done |=> init_done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    init_done |-> (pin_nop && ddr_cke && ddr_addr == '0));
endmodule

// File: tb/pwrup_seq_bench.sv
module pwrup_seq_bench;
  localparam int P    = 12;
  localparam int C    = 3;
  localparam int MRD  = 2;
  localparam int DLL  = 200;
  localparam int RP   = 4;
  localparam int RFC  = 14;
  localparam int SYNC = 2;

  localparam int K_CKE = SYNC + P;
  localparam int K_EM  = K_CKE + C;
  localparam int K_DR  = K_EM + MRD;
  localparam int K_PA  = K_DR + DLL;
  localparam int K_R1  = K_PA + RP;
  localparam int K_R2  = K_R1 + RFC;
  localparam int K_FM  = K_R2 + RFC;
  localparam int K_DN  = K_FM + MRD;
  localparam int K_END = K_DN + 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_burst;
  logic        cfg_interleave, cfg_cl4;
  logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [1:0]  ddr_ba;
  logic [11:0] ddr_addr;
  logic        init_done;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwrup_seq #(
    .POWER_WAIT (P), .CKE_LEAD (C), .MODE_GAP (MRD), .DLL_LOCK (DLL),
    .PRE_GAP (RP), .REF_GAP (RFC), .REF_COUNT (2)
  ) u_pwrup_seq (
    .clk (clk), .rst_n (rst_n),
    .cfg_burst (cfg_burst), .cfg_interleave (cfg_interleave), .cfg_cl4 (cfg_cl4),
    .ddr_cke (ddr_cke), .ddr_cs_n (ddr_cs_n), .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n), .ddr_we_n (ddr_we_n),
    .ddr_ba (ddr_ba), .ddr_addr (ddr_addr), .init_done (init_done)
  );

  // {cke, cs_n, ras_n, cas_n, we_n, ba[1:0], addr[11:0], done}
  function automatic logic [19:0] observed();
    return {ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_ba, ddr_addr, init_done};
  endfunction

  function automatic logic [11:0] word_of(input logic [1:0] b, input logic il, input logic cl4);
    logic [11:0] w;
    w = '0;
    w[2:0] = (b == 2'd0) ? 3'b001 : (b == 2'd1) ? 3'b010 : 3'b011;
    w[3]   = il;
    w[6:4] = cl4 ? 3'b100 : 3'b011;
    return w;
  endfunction

  function automatic logic [19:0] expected(input int k, input logic [11:0] w1, input logic [11:0] w2);
    logic       cke, dn;
    logic [3:0] pins;
    logic [1:0] ba;
    logic [11:0] ad;
    cke = (k >= K_CKE); dn = (k >= K_DN);
    pins = 4'b0111; ba = 2'b00; ad = '0;
    if (k == K_EM) begin pins = 4'b0000; ba = 2'b01; end
    else if (k == K_DR) begin pins = 4'b0000; ad = w1 | 12'h100; end
    else if (k == K_PA) begin pins = 4'b0010; ad = 12'h400; end
    else if (k == K_R1 || k == K_R2) pins = 4'b0001;
    else if (k == K_FM) begin pins = 4'b0000; ad = w2; end
    return {cke, pins, ba, ad, dn};
  endfunction

  function automatic string req_of(input int k);
    if (k < K_CKE) return "R1";
    if (k == K_EM) return "R2";
    if (k == K_DR) return "R3";
    if (k == K_PA) return "R4";
    if (k == K_R1 || k == K_R2) return "R5";
    if (k == K_FM) return "R6";
    if (k >= K_DN) return "R9";
    return "R8";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reset_state_check(input string req, input string what);
    check(observed() == {1'b0, 4'b0111, 2'b00, 12'h000, 1'b0}, req, what,
          32'(observed()), 32'({1'b0, 4'b0111, 2'b00, 12'h000, 1'b0}));
  endtask

  // full script; cfg switches from set 1 to set 2 just before the final mode write launches
  task automatic run_seq(input logic [1:0] b1, input logic il1, input logic c1,
                         input logic [1:0] b2, input logic il2, input logic c2);
    logic [11:0] w1, w2;
    w1 = word_of(b1, il1, c1);
    w2 = word_of(b2, il2, c2);
    cfg_burst = b1; cfg_interleave = il1; cfg_cl4 = c1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    reset_state_check("R1", "state while in reset");
    rst_n = 1'b1;
    for (int k = 1; k <= K_END; k++) begin
      @(negedge clk);
      check(observed() == expected(k, w1, w2), req_of(k), $sformatf("outputs at edge %0d", k),
            32'(observed()), 32'(expected(k, w1, w2)));
      if (k == K_FM) check(ddr_addr == w2, "R7", "final mode word", 32'(ddr_addr), 32'(w2));
      if (k == K_DR) check(ddr_addr == (w1 | 12'h100), "R7", "dll reset mode word",
                           32'(ddr_addr), 32'(w1 | 12'h100));
      if (k == K_FM - 1) begin cfg_burst = b2; cfg_interleave = il2; cfg_cl4 = c2; end
      if (k == K_DN + 2) begin cfg_burst = ~b2; cfg_interleave = ~il2; cfg_cl4 = ~c2; end
    end
  endtask

  task automatic test_basic();
    run_seq(2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic test_alt_cfg();
    run_seq(2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1);
    run_seq(2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic test_cfg_race();
    run_seq(2'd0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1);
  endtask

  // R10: reset during the DLL wait, then a clean restart
  task automatic test_mid_reset();
    cfg_burst = 2'd1; cfg_interleave = 1'b0; cfg_cl4 = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 1; k <= K_DR + 50; k++) @(negedge clk);
    check(ddr_cke == 1'b1, "R10", "cke high before mid reset", 32'(ddr_cke), 32'd1);
    #1 rst_n = 1'b0;
    #1 reset_state_check("R10", "outputs right after mid reset");
    run_seq(2'd2, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_burst = 2'd0; cfg_interleave = 1'b0; cfg_cl4 = 1'b0;
    test_basic();
    test_alt_cfg();
    test_cfg_race();
    test_mid_reset();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule